// File: doc/BRIEF.md
# Halfword Zero-Extending Move Unit

This block is the execute stage for one opcode group of a 36-bit word machine: the group that moves the right 18-bit half of a source word into a destination and clears the destination's left half. The caller presents the instruction word, a precomputed effective address (section and 18-bit offset) and the current program counter, then pulses `start` while the unit is idle. The unit reads an accumulator combinationally, drives a memory port with a valid/ready handshake, and finishes every instruction with a one-cycle `done` pulse. That pulse carries the accumulator write, the program-counter update or an error report.

The four members of the group differ only in where data comes from and where it goes. The load form copies memory into an accumulator. The immediate form takes the effective-address offset itself. The store form copies an accumulator to memory. The self form rewrites the memory word in place and also updates an accumulator unless the accumulator number is zero. A faulting memory read aborts the instruction cleanly so that it can be restarted from the beginning. An opcode outside the group raises a dispatch error that reports the PC, the instruction and the address.

Top module: `halfzx_exec`

## Requirements
- R1: The opcode is instruction bits [35:27]. The values octal 550, 551, 552 and 553 select the load, immediate, store and self forms. Any other value ends the instruction with `done` and `disp_err` and no memory access, accumulator write or PC update. `rep_pc`, `rep_insn` and `rep_ea` then show the PC {section,offset}, the instruction word and the address {section,offset}.
- R2: The load form reads the word at the effective address once and writes {18'b0, word[17:0]} to the accumulator numbered by instruction bits [3:0].
- R3: The immediate form makes no memory access and writes {18'b0, ea_off} to the selected accumulator.
- R4: The store form writes {18'b0, acc[17:0]} of the selected accumulator to the effective address and does not write any accumulator.
- R5: The self form reads the effective address and writes {18'b0, word[17:0]} back to the same address. It writes the same value to the selected accumulator only when the accumulator number is nonzero.
- R6: When a read response carries `mem_fault`, the instruction ends with `done` and `rd_fault`, and `rep_ea` gives the effective address. No accumulator write, memory write or PC update takes place.
- R7: On successful completion `pc_we` pulses with `pc_next` = {pc_sect, pc_off+1}, where the offset wraps modulo 2^18 inside the same section.
- R8: Each accepted instruction gives exactly one single-cycle `done`. `ac_we` and `pc_we` are asserted only in that cycle, and the unit is idle whenever `done` is high.
- R9: A memory request carries the effective address {section,offset}. Its address, direction and write data stay unchanged until `mem_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept an instruction (taken only when idle) |
| insn | input | 36 | Instruction word |
| ea_sect | input | 12 | Effective-address section |
| ea_off | input | 18 | Effective-address offset |
| pc_sect | input | 12 | Current PC section |
| pc_off | input | 18 | Current PC offset |
| idle | output | 1 | Unit ready for a new instruction |
| ac_raddr | output | 4 | Accumulator read index |
| ac_rdata | input | 36 | Accumulator read data (combinational) |
| ac_we | output | 1 | Accumulator write strobe |
| ac_waddr | output | 4 | Accumulator write index |
| ac_wdata | output | 36 | Accumulator write data |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 30 | Memory address {section,offset} |
| mem_wdata | output | 36 | Memory write data |
| mem_ready | input | 1 | Request accepted / response valid |
| mem_rdata | input | 36 | Read data |
| mem_fault | input | 1 | Read response is a page fault |
| done | output | 1 | Instruction finished |
| pc_we | output | 1 | PC update strobe |
| pc_next | output | 30 | Next PC {section,offset} |
| rd_fault | output | 1 | Read page fault ended the instruction |
| disp_err | output | 1 | Opcode not handled |
| rep_pc | output | 30 | Reported PC of the instruction |
| rep_insn | output | 36 | Reported instruction word |
| rep_ea | output | 30 | Reported effective address |

## Verification
The assertions check on every cycle that accumulator and PC strobes appear only with `done`, that a fault or dispatch error never comes with a commit, that written halves are zero on the left, and that a pending memory request holds still. The correct data path per form, the choice of accumulator, the skipped write for accumulator zero in self mode, the PC offset wrap and the untouched memory after a fault can only be seen in the bench. Its scenarios compare the accumulator and memory models with values computed from the requirements.

// File: rtl/halfzx_pkg.sv
package halfzx_pkg;
    localparam int OPC_W = 9;
    localparam logic [OPC_W-1:0] OPC_GROUP = 9'o550;

    typedef enum logic [2:0] {
        MD_LOAD,
        MD_IMM,
        MD_STORE,
        MD_BOTH,
        MD_BAD
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE
    } state_e;
endpackage

// File: rtl/halfzx_decode.sv
module halfzx_decode
    import halfzx_pkg::*;
#(
    parameter int WORD_W = 36,
    parameter int AC_AW  = 4
) (
    input  logic [WORD_W-1:0] insn,
    output mode_e             mode,
    output logic [AC_AW-1:0]  acn
);
    logic [OPC_W-1:0] opc;

    assign opc = insn[WORD_W-1 -: OPC_W];
    assign acn = insn[AC_AW-1:0];

    always_comb begin
        if (opc == OPC_GROUP)                       mode = MD_LOAD;
        else if (opc == OPC_GROUP + OPC_W'(1))      mode = MD_IMM;
        else if (opc == OPC_GROUP + OPC_W'(2))      mode = MD_STORE;
        else if (opc == OPC_GROUP + OPC_W'(3))      mode = MD_BOTH;
        else                                        mode = MD_BAD;
    end
endmodule

// File: rtl/halfzx_zext.sv
module halfzx_zext #(
    parameter int HALF_W = 18
) (
    input  logic [2*HALF_W-1:0] word,
    output logic [2*HALF_W-1:0] res
);
    assign res = {{HALF_W{1'b0}}, word[HALF_W-1:0]};
endmodule

// File: rtl/halfzx_pcinc.sv
module halfzx_pcinc #(
    parameter int SECT_W = 12,
    parameter int HALF_W = 18
) (
    input  logic [SECT_W-1:0]        sect,
    input  logic [HALF_W-1:0]        off,
    output logic [SECT_W+HALF_W-1:0] nxt
);
    logic [HALF_W-1:0] off_inc;

    assign off_inc = off + HALF_W'(1);
    assign nxt     = {sect, off_inc};
endmodule

// File: rtl/halfzx_exec.sv
module halfzx_exec
    import halfzx_pkg::*;
#(
    parameter int SECT_W = 12,
    parameter int HALF_W = 18,
    parameter int AC_N   = 16,
    localparam int WORD_W = 2 * HALF_W,
    localparam int AC_AW  = $clog2(AC_N),
    localparam int ADDR_W = SECT_W + HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] insn,
    input  logic [SECT_W-1:0] ea_sect,
    input  logic [HALF_W-1:0] ea_off,
    input  logic [SECT_W-1:0] pc_sect,
    input  logic [HALF_W-1:0] pc_off,
    output logic              idle,
    output logic [AC_AW-1:0]  ac_raddr,
    input  logic [WORD_W-1:0] ac_rdata,
    output logic              ac_we,
    output logic [AC_AW-1:0]  ac_waddr,
    output logic [WORD_W-1:0] ac_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_fault,
    output logic              done,
    output logic              pc_we,
    output logic [ADDR_W-1:0] pc_next,
    output logic              rd_fault,
    output logic              disp_err,
    output logic [ADDR_W-1:0] rep_pc,
    output logic [WORD_W-1:0] rep_insn,
    output logic [ADDR_W-1:0] rep_ea
);
    typedef struct packed {
        state_e              state;
        mode_e               mode;
        logic [AC_AW-1:0]    acn;
        logic [WORD_W-1:0]   insn;
        logic [SECT_W-1:0]   ea_sect;
        logic [HALF_W-1:0]   ea_off;
        logic [SECT_W-1:0]   pc_sect;
        logic [HALF_W-1:0]   pc_off;
        logic [WORD_W-1:0]   wdata;
        logic                done;
        logic                ac_we;
        logic [AC_AW-1:0]    ac_waddr;
        logic [WORD_W-1:0]   ac_wdata;
        logic                pc_we;
        logic [ADDR_W-1:0]   pc_next;
        logic                rd_fault;
        logic                disp_err;
    } regs_t;

    regs_t q, d;

    mode_e             dec_mode;
    logic [AC_AW-1:0]  dec_acn;
    logic [WORD_W-1:0] ac_zx;
    logic [WORD_W-1:0] rd_zx;
    logic [SECT_W-1:0] inc_sect;
    logic [HALF_W-1:0] inc_off;
    logic [ADDR_W-1:0] inc_pc;
    logic              in_idle;

    assign in_idle = (q.state == ST_IDLE);

    halfzx_decode #(.WORD_W(WORD_W), .AC_AW(AC_AW)) u_dec (
        .insn (insn),
        .mode (dec_mode),
        .acn  (dec_acn)
    );

    halfzx_zext #(.HALF_W(HALF_W)) u_zx_ac (
        .word (ac_rdata),
        .res  (ac_zx)
    );

    halfzx_zext #(.HALF_W(HALF_W)) u_zx_rd (
        .word (mem_rdata),
        .res  (rd_zx)
    );

    // One incrementer: live PC inputs for single-cycle forms, latched PC otherwise.
    assign inc_sect = in_idle ? pc_sect : q.pc_sect;
    assign inc_off  = in_idle ? pc_off  : q.pc_off;

    halfzx_pcinc #(.SECT_W(SECT_W), .HALF_W(HALF_W)) u_pc (
        .sect (inc_sect),
        .off  (inc_off),
        .nxt  (inc_pc)
    );

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.ac_we    = 1'b0;
        d.pc_we    = 1'b0;
        d.rd_fault = 1'b0;
        d.disp_err = 1'b0;

        case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.insn    = insn;
                    d.ea_sect = ea_sect;
                    d.ea_off  = ea_off;
                    d.pc_sect = pc_sect;
                    d.pc_off  = pc_off;
                    d.mode    = dec_mode;
                    d.acn     = dec_acn;
                    case (dec_mode)
                        MD_IMM: begin
                            d.ac_we    = 1'b1;
                            d.ac_waddr = dec_acn;
                            d.ac_wdata = {{HALF_W{1'b0}}, ea_off};
                            d.pc_we    = 1'b1;
                            d.pc_next  = inc_pc;
                            d.done     = 1'b1;
                        end
                        MD_STORE: begin
                            d.wdata = ac_zx;
                            d.state = ST_WRITE;
                        end
                        MD_LOAD, MD_BOTH: begin
                            d.state = ST_READ;
                        end
                        default: begin
                            d.disp_err = 1'b1;
                            d.done     = 1'b1;
                        end
                    endcase
                end
            end

            ST_READ: begin
                if (mem_ready) begin
                    if (mem_fault) begin
                        d.rd_fault = 1'b1;
                        d.done     = 1'b1;
                        d.state    = ST_IDLE;
                    end else if (q.mode == MD_BOTH) begin
                        d.wdata = rd_zx;
                        d.state = ST_WRITE;
                    end else begin
                        d.ac_we    = 1'b1;
                        d.ac_waddr = q.acn;
                        d.ac_wdata = rd_zx;
                        d.pc_we    = 1'b1;
                        d.pc_next  = inc_pc;
                        d.done     = 1'b1;
                        d.state    = ST_IDLE;
                    end
                end
            end

            ST_WRITE: begin
                if (mem_ready) begin
                    d.pc_we   = 1'b1;
                    d.pc_next = inc_pc;
                    d.done    = 1'b1;
                    d.state   = ST_IDLE;
                    if (q.mode == MD_BOTH && q.acn != '0) begin
                        d.ac_we    = 1'b1;
                        d.ac_waddr = q.acn;
                        d.ac_wdata = q.wdata;
                    end
                end
            end

            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign idle      = in_idle;
    assign ac_raddr  = insn[AC_AW-1:0];
    assign ac_we     = q.ac_we;
    assign ac_waddr  = q.ac_waddr;
    assign ac_wdata  = q.ac_wdata;
    assign mem_req   = (q.state == ST_READ) || (q.state == ST_WRITE);
    assign mem_we    = (q.state == ST_WRITE);
    assign mem_addr  = {q.ea_sect, q.ea_off};
    assign mem_wdata = q.wdata;
    assign done      = q.done;
    assign pc_we     = q.pc_we;
    assign pc_next   = q.pc_next;
    assign rd_fault  = q.rd_fault;
    assign disp_err  = q.disp_err;
    assign rep_pc    = {q.pc_sect, q.pc_off};
    assign rep_insn  = q.insn;
    assign rep_ea    = {q.ea_sect, q.ea_off};
endmodule

// File: rtl/halfzx_exec_chk.sv
module halfzx_exec_chk #(
    parameter int SECT_W = 12,
    parameter int HALF_W = 18,
    localparam int WORD_W = 2 * HALF_W,
    localparam int ADDR_W = SECT_W + HALF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              idle,
    input logic              ac_we,
    input logic [WORD_W-1:0] ac_wdata,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic              done,
    input logic              pc_we,
    input logic              rd_fault,
    input logic              disp_err
);
    a_r8_acwe_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        ac_we |-> done);

    a_r7_pcwe_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |-> done);

    a_r8_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (idle && !mem_req));

    a_r6_fault_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fault |-> (done && !ac_we && !pc_we && !disp_err));

    a_r1_bad_op_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        disp_err |-> (done && !ac_we && !pc_we));

    a_r2_ac_left_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ac_we |-> (ac_wdata[WORD_W-1:HALF_W] == '0));

    a_r4_mem_left_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[WORD_W-1:HALF_W] == '0));

    a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we)
                                      && $stable(mem_addr) && $stable(mem_wdata)));
endmodule

bind halfzx_exec halfzx_exec_chk #(.SECT_W(SECT_W), .HALF_W(HALF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle      (idle),
    .ac_we     (ac_we),
    .ac_wdata  (ac_wdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .done      (done),
    .pc_we     (pc_we),
    .rd_fault  (rd_fault),
    .disp_err  (disp_err)
);

// File: tb/halfzx_exec_test.sv
module halfzx_exec_test;
    localparam int SW = 12;
    localparam int HW = 18;
    localparam int WW = 36;
    localparam int AW = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [WW-1:0] insn = '0;
    logic [SW-1:0] ea_sect = '0;
    logic [HW-1:0] ea_off = '0;
    logic [SW-1:0] pc_sect = '0;
    logic [HW-1:0] pc_off = '0;
    logic idle;
    logic [3:0] ac_raddr;
    logic [WW-1:0] ac_rdata;
    logic ac_we;
    logic [3:0] ac_waddr;
    logic [WW-1:0] ac_wdata;
    logic mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [WW-1:0] mem_wdata;
    logic mem_ready = 1'b0;
    logic [WW-1:0] mem_rdata = '0;
    logic mem_fault = 1'b0;
    logic done, pc_we, rd_fault, disp_err;
    logic [AW-1:0] pc_next, rep_pc, rep_ea;
    logic [WW-1:0] rep_insn;

    logic [WW-1:0] acf [16];
    logic [WW-1:0] mem [64];
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    assign ac_rdata = acf[ac_raddr];

    halfzx_exec uut (
        .clk(clk), .rst_n(rst_n), .start(start), .insn(insn),
        .ea_sect(ea_sect), .ea_off(ea_off), .pc_sect(pc_sect), .pc_off(pc_off),
        .idle(idle), .ac_raddr(ac_raddr), .ac_rdata(ac_rdata),
        .ac_we(ac_we), .ac_waddr(ac_waddr), .ac_wdata(ac_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .mem_fault(mem_fault), .done(done), .pc_we(pc_we), .pc_next(pc_next),
        .rd_fault(rd_fault), .disp_err(disp_err), .rep_pc(rep_pc),
        .rep_insn(rep_insn), .rep_ea(rep_ea)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] zx(input logic [WW-1:0] w);
        return {{HW{1'b0}}, w[HW-1:0]};
    endfunction

    function automatic string form_tag(input logic [8:0] op);
        case (op)
            9'o550:  return "R2";
            9'o551:  return "R3";
            9'o552:  return "R4";
            9'o553:  return "R5";
            default: return "R1";
        endcase
    endfunction

    task automatic run(input logic [8:0] op, input logic [3:0] acn,
                       input logic [SW-1:0] es, input logic [HW-1:0] eo,
                       input logic [SW-1:0] ps, input logic [HW-1:0] po,
                       input bit flt);
        bit valid = (op >= 9'o550) && (op <= 9'o553);
        bit reads = (op == 9'o550) || (op == 9'o553);
        bit efl = reads && flt;
        string tg = form_tag(op);
        logic [WW-1:0] iw = {op, 23'($urandom), acn};
        logic [5:0] idx = eo[5:0];
        logic [WW-1:0] old = mem[idx];
        logic [WW-1:0] acold = acf[acn];
        int exp_rd = reads ? 1 : 0;
        int exp_wr = ((op == 9'o552) || (op == 9'o553 && !flt)) ? 1 : 0;
        bit exp_acwe = !efl && ((op == 9'o550) || (op == 9'o551) ||
                                (op == 9'o553 && acn != 4'd0));
        logic [WW-1:0] exp_acd = (op == 9'o551) ? {{HW{1'b0}}, eo} : zx(old);
        logic [WW-1:0] exp_mem = (op == 9'o552) ? zx(acold) :
                                 (op == 9'o553 && !flt) ? zx(old) : old;
        bit exp_pcwe = valid && !efl;
        logic [AW-1:0] exp_pc = {ps, po + 18'd1};
        int nrd = 0, nwr = 0, lat = 0;
        bit got = 0;
        bit s_acwe = 0, s_pcwe = 0, s_flt = 0, s_derr = 0;
        logic [3:0] s_wa = '0;
        logic [WW-1:0] s_wd = '0, s_insn = '0;
        logic [AW-1:0] s_pc = '0, s_rpc = '0, s_rea = '0;

        @(negedge clk);
        insn = iw; ea_sect = es; ea_off = eo; pc_sect = ps; pc_off = po;
        start = 1'b1;
        for (int cyc = 0; cyc < 40 && !got; cyc++) begin
            @(negedge clk);
            if (cyc == 0) start = 1'b0;
            if (mem_ready) begin
                mem_ready = 1'b0;
                mem_fault = 1'b0;
            end else if (mem_req) begin
                if (lat > 0) lat--;
                else begin
                    chk(mem_addr == {es, eo}, "R9", 64'(mem_addr), 64'({es, eo}));
                    if (mem_we) begin
                        mem[mem_addr[5:0]] = mem_wdata;
                        nwr++;
                    end else begin
                        nrd++;
                        mem_fault = flt;
                        mem_rdata = flt ? 36'h5A5A5A5A5 : mem[idx];
                    end
                    mem_ready = 1'b1;
                    lat = $urandom % 3;
                end
            end
            if (done) begin
                got = 1;
                s_acwe = ac_we; s_wa = ac_waddr; s_wd = ac_wdata;
                s_pcwe = pc_we; s_pc = pc_next; s_flt = rd_fault;
                s_derr = disp_err; s_rpc = rep_pc; s_insn = rep_insn; s_rea = rep_ea;
            end
        end
        chk(got, "R8", 64'(got), 64'd1);
        if (s_acwe) acf[s_wa] = s_wd;

        chk(s_derr == !valid, "R1", 64'(s_derr), 64'(!valid));
        if (!valid) begin
            chk(s_insn == iw, "R1", 64'(s_insn), 64'(iw));
            chk(s_rpc == {ps, po}, "R1", 64'(s_rpc), 64'({ps, po}));
            chk(s_rea == {es, eo}, "R1", 64'(s_rea), 64'({es, eo}));
        end
        chk(nrd == exp_rd, tg, 64'(nrd), 64'(exp_rd));
        chk(nwr == exp_wr, tg, 64'(nwr), 64'(exp_wr));
        chk(s_acwe == exp_acwe, efl ? "R6" : tg, 64'(s_acwe), 64'(exp_acwe));
        if (exp_acwe && s_acwe) begin
            chk(s_wa == acn, tg, 64'(s_wa), 64'(acn));
            chk(s_wd == exp_acd, tg, 64'(s_wd), 64'(exp_acd));
        end
        chk(mem[idx] == exp_mem, efl ? "R6" : tg, 64'(mem[idx]), 64'(exp_mem));
        chk(s_flt == efl, "R6", 64'(s_flt), 64'(efl));
        if (efl) chk(s_rea == {es, eo}, "R6", 64'(s_rea), 64'({es, eo}));
        chk(s_pcwe == exp_pcwe, "R7", 64'(s_pcwe), 64'(exp_pcwe));
        if (exp_pcwe && s_pcwe) chk(s_pc == exp_pc, "R7", 64'(s_pc), 64'(exp_pc));
        @(negedge clk);
        chk(!done && !ac_we && !pc_we, "R8", 64'({done, ac_we, pc_we}), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) acf[i] = {$urandom, $urandom} & {WW{1'b1}};
        for (int i = 0; i < 64; i++) mem[i] = {$urandom, $urandom} & {WW{1'b1}};
        repeat (3) @(negedge clk);
        chk(!done && !mem_req && !ac_we && !pc_we && idle, "R8",
            64'({done, mem_req, ac_we, pc_we, idle}), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !mem_req && idle, "R8", 64'({done, mem_req, idle}), 64'd1);

        acf[5] = 36'h7FFFF0001;
        mem[8] = 36'h123456789;
        run(9'o550, 4'd5, 12'h003, 18'h00008, 12'h001, 18'h00100, 1'b0); // R2
        run(9'o551, 4'd2, 12'h003, 18'h2ABCD, 12'h001, 18'h00101, 1'b0); // R3
        acf[7] = 36'hFFFFFFFFF;
        run(9'o552, 4'd7, 12'h004, 18'h00011, 12'h001, 18'h00102, 1'b0); // R4
        mem[20] = 36'hABCDE1234;
        run(9'o553, 4'd9, 12'h004, 18'h00014, 12'h001, 18'h00103, 1'b0); // R5 acc nonzero
        acf[0] = 36'h000010000;
        mem[21] = 36'h777771111;
        run(9'o553, 4'd0, 12'h004, 18'h00015, 12'h001, 18'h00104, 1'b0); // R5 acc zero kept
        chk(acf[0] == 36'h000010000, "R5", 64'(acf[0]), 64'h000010000);
        run(9'o550, 4'd3, 12'h002, 18'h00030, 12'h001, 18'h00105, 1'b1); // R6 load fault
        run(9'o553, 4'd4, 12'h002, 18'h00031, 12'h001, 18'h00106, 1'b1); // R6 self fault
        run(9'o551, 4'd1, 12'h000, 18'h3FFFF, 12'h7FF, 18'h3FFFF, 1'b0); // R7 offset wrap
        run(9'o547, 4'd6, 12'h00A, 18'h00022, 12'h00B, 18'h00200, 1'b0); // R1 below group
        run(9'o554, 4'd6, 12'h00A, 18'h00023, 12'h00B, 18'h00201, 1'b0); // R1 above group

        for (int n = 0; n < 200; n++) begin
            logic [8:0] op = 9'o546 + 9'($urandom % 8);
            run(op, 4'($urandom), 12'($urandom), 18'($urandom), 12'($urandom),
                18'($urandom), ($urandom % 6) == 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule